// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Aggregator

This block collects 112 active-high interrupt sources into a single interrupt line and exposes them through a small register space. The sources are grouped eight to a block, seven blocks to a master, and two masters. Every block owns four directly addressed registers: the latched flags, a write-one-to-clear strobe, a per-bit mask, and a view of the raw inputs. Software never has to select a block before reaching its registers.

Each master has one summary register. Bits 7 down to 1 tell which of its blocks hold an unmasked latched flag. In the summary of master 0, bit 0 reports that master 1 has something pending. A handler can therefore read a single register first and only visit master 1 when that flag is set. The interrupt output is high whenever any unmasked latched flag exists anywhere.

Top module: `irq_cascade_agg`

## Requirements
- R1: While reset is held and after reset, every latched flag is 0, every mask register reads 0xFF, and `irq_o` is 0.
- R2: Master m (0 or 1) starts at 0x130 + m*0x80. Its summary register is at that base. Its block b (1..7) sits at base + b*0x10, with latched status at +0, clear at +1, mask at +2 and raw status at +3. Bit i of block b of master m is source number (m*7 + b - 1)*8 + i.
- R3: A latched flag becomes 1 on the clock edge at which its source input is high and its mask bit is 0. It then stays 1 until it is cleared, even after the input falls.
- R4: Writing a 1 to a bit of a clear register zeroes that latched flag at the next edge, and 0 bits have no effect. The clear wins over a set in the same cycle, so an input that is still high sets the flag again one cycle later. A clear register always reads 0.
- R5: The mask register can be read and written. A 1 bit blocks its source from latching, and a flag that is already latched is kept. A mask write takes effect at the edge that stores it, so the latch decision at that same edge still uses the old mask.
- R6: The raw status register returns the current source inputs of the block, whatever the mask is.
- R7: Bit b (1..7) of a master summary is 1 exactly when block b of that master has a latched flag whose mask bit is 0.
- R8: Bit 0 of the master 0 summary is 1 exactly when any of bits 7:1 of the master 1 summary is 1. Bit 0 of the master 1 summary reads 0.
- R9: `irq_o` is 1 exactly when some latched flag has its mask bit at 0.
- R10: Every address outside the registers of R2 reads 0, and writes to it change nothing. Writes to status, raw status and summary registers are ignored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 112 | Interrupt source inputs, active high |
| bus_addr_i | input | 10 | Register address for reads and writes |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
Two pairs of events can fall into one edge. In the first, a clear is written while the source is still high. In the second, a mask write is issued in the same cycle as a rising source. Both are provoked on purpose: the bench reads the status register in the cycle right after the edge and again one cycle later. It expects 0 then 1 in the clear case, where the clear wins and the flag sets again. It expects 0 then 1 in the mask case, where the old mask governs that edge. A long random phase then drives sources, clears and mask writes in the same cycles at will, and a behavioural model judges the read data and the interrupt line every cycle.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

    // Kind of register selected by the current address
    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_SUMMARY,
        KIND_STATUS,
        KIND_CLEAR,
        KIND_MASK,
        KIND_RAW
    } reg_kind_e;

    // Register offsets inside one block window
    localparam int OFF_STATUS = 0;
    localparam int OFF_CLEAR  = 1;
    localparam int OFF_MASK   = 2;
    localparam int OFF_RAW    = 3;

endpackage

// File: rtl/irq_agg_decode.sv
`timescale 1ns/1ps
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BASE_ADDR   = 32'h130,
    parameter int MASTER_SPAN = 32'h80,
    parameter int STRIDE_LG   = 4,
    parameter int NUM_MASTERS = 2,
    parameter int BPM         = 7,
    parameter int MW          = 1,
    parameter int BW          = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [MW-1:0]     master_o,
    output logic [BW-1:0]     block_o
);

    localparam int AW1    = ADDR_W + 1;
    localparam int REGION = (BPM + 1) << STRIDE_LG;

    logic [AW1-1:0]       off;
    logic [BW-1:0]        lblk;
    logic [STRIDE_LG-1:0] roff;

    always_comb begin
        kind_o   = KIND_NONE;
        master_o = '0;
        block_o  = '0;
        off      = '0;
        lblk     = '0;
        roff     = '0;
        for (int m = 0; m < NUM_MASTERS; m++) begin
            off = {1'b0, addr_i} - AW1'(BASE_ADDR + m * MASTER_SPAN);
            if (off < AW1'(REGION)) begin
                lblk     = BW'(off >> STRIDE_LG);
                roff     = off[STRIDE_LG-1:0];
                master_o = MW'(m);
                block_o  = lblk;
                if (lblk == '0) begin
                    kind_o = (roff == '0) ? KIND_SUMMARY : KIND_NONE;
                end else begin
                    case (int'(roff))
                        OFF_STATUS: kind_o = KIND_STATUS;
                        OFF_CLEAR:  kind_o = KIND_CLEAR;
                        OFF_MASK:   kind_o = KIND_MASK;
                        OFF_RAW:    kind_o = KIND_RAW;
                        default:    kind_o = KIND_NONE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/irq_agg_block.sv
`timescale 1ns/1ps
module irq_agg_block #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         clr_we_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] mask;
    } blk_state_t;

    blk_state_t   st_d;
    blk_state_t   st_q;
    logic [W-1:0] clr_bits;

    always_comb begin
        st_d     = st_q;
        clr_bits = clr_we_i ? wdata_i : '0;
        // set from unmasked inputs, clear strobe has priority
        st_d.flag = (st_q.flag | (src_i & ~st_q.mask)) & ~clr_bits;
        if (mask_we_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign mask_o = st_q.mask;
    assign pend_o = |(st_q.flag & ~st_q.mask);

endmodule

// File: rtl/irq_agg_summary.sv
`timescale 1ns/1ps
module irq_agg_summary #(
    parameter int NUM_MASTERS = 2,
    parameter int BPM         = 7
) (
    input  logic [NUM_MASTERS*BPM-1:0]     pend_i,
    output logic [NUM_MASTERS-1:0][BPM:0]  summ_o,
    output logic                           irq_o
);

    // Walk from the last master upward so each one sees
    // whether anything further down the chain is pending.
    always_comb begin
        logic later_pend;
        later_pend = 1'b0;
        for (int m = NUM_MASTERS - 1; m >= 0; m--) begin
            summ_o[m]  = {pend_i[m*BPM +: BPM], later_pend};
            later_pend = later_pend | (|pend_i[m*BPM +: BPM]);
        end
    end

    assign irq_o = |pend_i;

endmodule

// File: rtl/irq_cascade_agg.sv
`timescale 1ns/1ps
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_MASTERS       = 2,
    parameter int BLOCKS_PER_MASTER = 7,
    parameter int SRC_PER_BLOCK     = 8,
    parameter int ADDR_W            = 10,
    parameter int BASE_ADDR         = 32'h130,
    parameter int MASTER_SPAN       = 32'h80,
    parameter int STRIDE_LG         = 4
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [NUM_MASTERS*BLOCKS_PER_MASTER*SRC_PER_BLOCK-1:0] src_i,
    input  logic [ADDR_W-1:0]                                   bus_addr_i,
    input  logic                                                bus_we_i,
    input  logic [SRC_PER_BLOCK-1:0]                            bus_wdata_i,
    output logic [SRC_PER_BLOCK-1:0]                            bus_rdata_o,
    output logic                                                irq_o
);

    localparam int DW   = SRC_PER_BLOCK;
    localparam int BPM  = BLOCKS_PER_MASTER;
    localparam int NBLK = NUM_MASTERS * BPM;
    localparam int MW   = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
    localparam int BW   = $clog2(BPM + 1);
    localparam int GW   = (NBLK > 1) ? $clog2(NBLK) : 1;

    reg_kind_e                        dec_kind;
    logic [MW-1:0]                    dec_master;
    logic [BW-1:0]                    dec_block;
    logic [NBLK-1:0][DW-1:0]          flag_all;
    logic [NBLK-1:0][DW-1:0]          mask_all;
    logic [NBLK-1:0]                  pend_all;
    logic [NUM_MASTERS-1:0][BPM:0]    summ;
    logic [GW-1:0]                    gidx;

    irq_agg_decode #(
        .ADDR_W      (ADDR_W),
        .BASE_ADDR   (BASE_ADDR),
        .MASTER_SPAN (MASTER_SPAN),
        .STRIDE_LG   (STRIDE_LG),
        .NUM_MASTERS (NUM_MASTERS),
        .BPM         (BPM),
        .MW          (MW),
        .BW          (BW)
    ) u_dec (
        .addr_i   (bus_addr_i),
        .kind_o   (dec_kind),
        .master_o (dec_master),
        .block_o  (dec_block)
    );

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
        for (genvar b = 0; b < BPM; b++) begin : g_block
            localparam int G = m * BPM + b;
            logic hit;
            logic clr_we;
            logic mask_we;

            assign hit     = (dec_master == MW'(m)) && (dec_block == BW'(b + 1));
            assign clr_we  = bus_we_i && hit && (dec_kind == KIND_CLEAR);
            assign mask_we = bus_we_i && hit && (dec_kind == KIND_MASK);

            irq_agg_block #(
                .W (DW)
            ) u_blk (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_i     (src_i[G*DW +: DW]),
                .clr_we_i  (clr_we),
                .mask_we_i (mask_we),
                .wdata_i   (bus_wdata_i),
                .flag_o    (flag_all[G]),
                .mask_o    (mask_all[G]),
                .pend_o    (pend_all[G])
            );
        end
    end

    irq_agg_summary #(
        .NUM_MASTERS (NUM_MASTERS),
        .BPM         (BPM)
    ) u_sum (
        .pend_i (pend_all),
        .summ_o (summ),
        .irq_o  (irq_o)
    );

    // Read path: one register selected by the decoded address
    always_comb begin
        gidx        = GW'(int'(dec_master) * BPM + int'(dec_block) - 1);
        bus_rdata_o = '0;
        case (dec_kind)
            KIND_SUMMARY: bus_rdata_o = DW'(summ[dec_master]);
            KIND_STATUS:  bus_rdata_o = flag_all[gidx];
            KIND_MASK:    bus_rdata_o = mask_all[gidx];
            KIND_RAW:     bus_rdata_o = src_i[gidx*DW +: DW];
            default:      bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg_checker.sv
`timescale 1ns/1ps
module irq_agg_checker #(
    parameter int NSRC      = 112,
    parameter int DW        = 8,
    parameter int ADDR_W    = 10,
    parameter int BASE_ADDR = 32'h130,
    parameter int STRIDE_LG = 4,
    parameter int M0_SRC    = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DW-1:0]     bus_rdata_o,
    input logic              irq_o,
    input logic [NSRC-1:0]   flags,
    input logic [NSRC-1:0]   masks,
    input logic [NSRC-1:0]   src
);

    localparam logic [ADDR_W-1:0] SUMM0_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] CLR01_ADDR = ADDR_W'(BASE_ADDR + (1 << STRIDE_LG) + 1);

    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & $past(masks)) == '0)); // R5

    AST_SET_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(src)) == '0)); // R3

    AST_IRQ_ANY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o == (|(flags & ~masks)))); // R9

    AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == CLR01_ADDR) |-> (bus_rdata_o == '0)); // R4

    AST_UNDEF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == '0) |-> (bus_rdata_o == '0)); // R10

    AST_CASCADE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == SUMM0_ADDR) |->
        (bus_rdata_o[0] == (|(flags[NSRC-1:M0_SRC] & ~masks[NSRC-1:M0_SRC])))); // R8

endmodule

bind irq_cascade_agg irq_agg_checker #(
    .NSRC      (NUM_MASTERS * BLOCKS_PER_MASTER * SRC_PER_BLOCK),
    .DW        (SRC_PER_BLOCK),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .STRIDE_LG (STRIDE_LG),
    .M0_SRC    (BLOCKS_PER_MASTER * SRC_PER_BLOCK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .flags       (flag_all),
    .masks       (mask_all),
    .src         (src_i)
);

// File: tb/test_irq_cascade_agg.sv
`timescale 1ns/1ps
module test_irq_cascade_agg;

    localparam int NSRC = 112;

    logic            clk;
    logic            rst_n;
    logic [NSRC-1:0] src;
    logic [9:0]      addr;
    logic            we;
    logic [7:0]      wdata;
    logic [7:0]      rdata;
    logic            irq;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 0;

    bit mflag [NSRC];
    bit mmask [NSRC];

    irq_cascade_agg i_irq_cascade_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;   // 10 ns period, 100 MHz

    // ---------------- reference model ----------------
    function automatic int reg_addr(int m, int b, int r);
        return 'h130 + m * 'h80 + b * 'h10 + r;
    endfunction

    // 0 none, 1 summary, 2 status, 3 clear, 4 mask, 5 raw
    function automatic int kind_of(int a, output int m, output int b);
        m = 0;
        b = 0;
        for (int mm = 0; mm < 2; mm++) begin
            int off;
            off = a - ('h130 + mm * 'h80);
            if (off >= 0 && off < 'h80) begin
                m = mm;
                b = off / 16;
                if (b == 0) return ((off % 16) == 0) ? 1 : 0;
                case (off % 16)
                    0: return 2;
                    1: return 3;
                    2: return 4;
                    3: return 5;
                    default: return 0;
                endcase
            end
        end
        return 0;
    endfunction

    function automatic bit blk_pend(int m, int b);
        for (int i = 0; i < 8; i++) begin
            int s;
            s = (m * 7 + b - 1) * 8 + i;
            if (mflag[s] && !mmask[s]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit exp_irq();
        for (int s = 0; s < NSRC; s++) if (mflag[s] && !mmask[s]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int exp_read(int a);
        int m, b, k, base;
        bit [7:0] v;
        v = 8'h00;
        k = kind_of(a, m, b);
        base = (m * 7 + b - 1) * 8;
        case (k)
            1: begin
                for (int j = 1; j < 8; j++) v[j] = blk_pend(m, j);
                if (m == 0) for (int j = 1; j < 8; j++) if (blk_pend(1, j)) v[0] = 1'b1;
            end
            2: for (int i = 0; i < 8; i++) v[i] = mflag[base + i];
            4: for (int i = 0; i < 8; i++) v[i] = mmask[base + i];
            5: for (int i = 0; i < 8; i++) v[i] = src[base + i];
            default: v = 8'h00;
        endcase
        return int'(v);
    endfunction

    function automatic string tag_of(int a);
        int m, b;
        case (kind_of(a, m, b))
            1: return "R7/R8 summary";
            2: return "R3 status";
            3: return "R4 clear";
            4: return "R5 mask";
            5: return "R6 raw";
            default: return "R10 undefined";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) begin
                mflag[s] = 1'b0;
                mmask[s] = 1'b1;
            end
        end else begin
            int m, b, k, base;
            k = kind_of(int'(addr), m, b);
            base = (m * 7 + b - 1) * 8;
            for (int s = 0; s < NSRC; s++) begin
                bit clr;
                clr = we && (k == 3) && (s >= base) && (s < base + 8) && wdata[s - base];
                mflag[s] = clr ? 1'b0 : (mflag[s] | (src[s] & !mmask[s]));
            end
            if (we && k == 4) for (int i = 0; i < 8; i++) mmask[base + i] = wdata[i];
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always begin
        @(negedge clk);
        #2;
        if (rst_n && !done) begin
            chk("R9 irq per cycle", int'(irq), int'(exp_irq()));
            chk(tag_of(int'(addr)), int'(rdata), exp_read(int'(addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr  = 10'(a);
        we    = 1'b1;
        wdata = 8'(d);
        @(negedge clk);
        we    = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk);
        addr = 10'(a);
        we   = 1'b0;
        #2;
        chk(tag, int'(rdata), exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [127:0] rnd;
        rst_n = 1'b0;
        src   = '0;
        addr  = '0;
        we    = 1'b0;
        wdata = '0;
        repeat (3) @(negedge clk);
        // R1: values under reset
        addr = 10'(reg_addr(0, 1, 2));
        #2;
        chk("R1 mask reset", int'(rdata), 'hFF);
        chk("R1 irq reset", int'(irq), 0);
        addr = 10'(reg_addr(1, 7, 0));
        #1;
        chk("R1 flag reset", int'(rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: masked source is not latched
        src[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(reg_addr(0, 1, 0), 0, "R5 masked source not latched");
        rd(reg_addr(0, 0, 0), 0, "R7 summary empty");
        chk("R9 irq low while masked", int'(irq), 0);

        // R3/R5/R7/R9: unmask and latch
        wr(reg_addr(0, 1, 2), 'hFE);
        rd(reg_addr(0, 1, 0), 'h01, "R3 flag latched");
        rd(reg_addr(0, 1, 2), 'hFE, "R5 mask readback");
        rd(reg_addr(0, 0, 0), 'h02, "R7 summary block 1");
        chk("R9 irq high", int'(irq), 1);
        rd(reg_addr(0, 1, 3), 'h01, "R6 raw input");
        rd(reg_addr(0, 1, 1), 0, "R4 clear reads zero");

        // R4: clear while input still high
        @(negedge clk);
        addr = 10'(reg_addr(0, 1, 1)); we = 1'b1; wdata = 8'h01;
        @(negedge clk);
        we = 1'b0; addr = 10'(reg_addr(0, 1, 0));
        #2;
        chk("R4 clear wins this edge", int'(rdata), 0);
        @(negedge clk);
        #2;
        chk("R4 set again next edge", int'(rdata), 1);

        // R3: flag holds after input falls, then clear
        src[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd(reg_addr(0, 1, 0), 'h01, "R3 flag holds after input falls");
        wr(reg_addr(0, 1, 1), 'h01);
        rd(reg_addr(0, 1, 0), 0, "R4 cleared");
        chk("R9 irq low after clear", int'(irq), 0);

        // R2/R8: master 1, block 3, bit 5 is source 77
        wr(reg_addr(1, 3, 2), 'hDF);
        src[77] = 1'b1;
        @(negedge clk);
        src[77] = 1'b0;
        rd(reg_addr(1, 3, 0), 'h20, "R2 source 77 mapping");
        rd(reg_addr(1, 0, 0), 'h08, "R7 master 1 summary");
        rd(reg_addr(0, 0, 0), 'h01, "R8 cascade flag");
        chk("R9 irq from master 1", int'(irq), 1);

        // R5: masking a latched flag keeps it but hides it
        wr(reg_addr(1, 3, 2), 'hFF);
        rd(reg_addr(1, 3, 0), 'h20, "R5 latched flag kept");
        rd(reg_addr(0, 0, 0), 0, "R8 cascade drops when masked");
        chk("R9 irq low when masked", int'(irq), 0);
        wr(reg_addr(1, 3, 1), 'h20);
        rd(reg_addr(1, 3, 0), 0, "R4 master 1 clear");

        // R5: mask write in the same cycle as a high input
        src[8] = 1'b1;
        @(negedge clk);
        addr = 10'(reg_addr(0, 2, 2)); we = 1'b1; wdata = 8'hFE;
        @(negedge clk);
        we = 1'b0; addr = 10'(reg_addr(0, 2, 0));
        #2;
        chk("R5 old mask governs write edge", int'(rdata), 0);
        @(negedge clk);
        #2;
        chk("R5 new mask governs next edge", int'(rdata), 1);
        src[8] = 1'b0;
        wr(reg_addr(0, 2, 1), 'h01);
        wr(reg_addr(0, 2, 2), 'hFF);

        // R10: undefined addresses and read-only registers
        rd('h100, 0, "R10 below map");
        rd(reg_addr(0, 0, 5), 0, "R10 summary hole");
        rd(reg_addr(0, 2, 7), 0, "R10 block hole");
        rd('h3FF, 0, "R10 top address");
        wr(reg_addr(0, 2, 5), 'h00);
        rd(reg_addr(0, 2, 2), 'hFF, "R10 hole write ignored");
        wr(reg_addr(0, 4, 0), 'hFF);
        rd(reg_addr(0, 4, 0), 0, "R10 status write ignored");
        wr(reg_addr(1, 0, 0), 'hFF);
        rd(reg_addr(1, 0, 0), 0, "R10 summary write ignored");

        // random traffic, judged by the model each cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            rnd = {$urandom(), $urandom(), $urandom(), $urandom()};
            src = rnd[NSRC-1:0] & {$urandom(), $urandom(), $urandom(), $urandom()};
            we  = (($urandom() % 4) == 0);
            wdata = 8'($urandom());
            if (($urandom() % 4) != 0)
                addr = 10'(reg_addr(int'($urandom() % 2), int'($urandom() % 8),
                                    int'($urandom() % 4)));
            else
                addr = 10'($urandom());
        end
        @(negedge clk);
        we = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule